// File: doc/BRIEF.md
# Qualified data trace message generator

This block watches single-beat transactions on a core's data bus and turns selected accesses into compact trace records for a debug output queue. An access is reported only when it passes two filters: its direction must match the configured access kind (loads only, stores only, or both), and its address must lie inside an inclusive window between a low and a high bound. If the low bound is above the high bound, the window is empty and no access matches.

To save output bandwidth, a normal record does not carry the full address. It carries the XOR of the current address and the last reported address, with the leading zero bits removed, and a length field that counts the significant bits kept. A record of this kind always includes the accessed data word. The first record after trace is enabled is a synchronisation record with the full address. The same applies to the first record after a record had to be dropped because the output queue was full. A decoder can therefore rebuild every address from the last synchronisation record onwards.

Each record appears one clock after the bus access it describes. It is held valid for that single cycle only.

Top module: `dtrace_msg_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `msg_valid` is 0.
- R2: `cfg_kind` selects which directions qualify: 0 = none, 1 = reads only (`bus_write`=0), 2 = writes only (`bus_write`=1), 3 = both. `msg_write` repeats the direction of the reported access.
- R3: An access qualifies only if `cfg_lo <= bus_addr <= cfg_hi`, with both bounds included. When `cfg_lo > cfg_hi`, no access qualifies.
- R4: While `cfg_enable` is 0, no record is produced.
- R5: The first record after `cfg_enable` rises, and the first record after reset, is a sync record with `msg_tcode` = 13, `msg_alen` = 32 and `msg_addr` equal to the full access address.
- R6: Other records carry `msg_tcode` = 5 for a write and 6 for a read. `msg_addr` is the reference address XOR the access address. `msg_alen` is the index of that value's highest set bit plus one, or 0 when the value is zero, so every bit of `msg_addr` at or above `msg_alen` is 0.
- R7: The reference address is the address of the most recent record emitted, whether sync or compressed. Repeating the same address gives `msg_alen` = 0 and `msg_addr` = 0.
- R8: If an access qualifies while `oq_full` is 1, no record is produced and the next record emitted is a sync record.
- R9: A qualifying access in cycle n produces `msg_valid` = 1 in cycle n+1 only. A cycle with no qualifying access produces `msg_valid` = 0 in the cycle after it.
- R10: `msg_data` equals `bus_data` of the reported access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Trace enable |
| cfg_kind | input | 2 | Access kind filter: 0 none, 1 read, 2 write, 3 both |
| cfg_lo | input | 32 | Window low bound, included |
| cfg_hi | input | 32 | Window high bound, included |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_addr | input | 32 | Access address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_data | input | 32 | Access data |
| oq_full | input | 1 | Output queue cannot accept a record this cycle |
| msg_valid | output | 1 | A record is present this cycle |
| msg_tcode | output | 6 | Transfer code: 5 write, 6 read, 13 sync |
| msg_write | output | 1 | Direction of the reported access |
| msg_alen | output | 6 | Number of significant address bits in `msg_addr` |
| msg_addr | output | 32 | Full address (sync) or trimmed XOR difference |
| msg_data | output | 32 | Data of the reported access |

## Verification
On every cycle, the assertions check the following: the legal transfer codes, that the length field bounds the address field, that sync records carry full length, and that no record follows a disabled cycle or a full queue. They also check that a drop always arms a resynchronisation and that every record follows a bus access. Only the bench's scenarios can show that the compressed address actually decodes against the right reference, and that the window bounds are included at both ends. The same holds for the empty-window case, for each access kind filtering correctly, and for the data word being the one of the reported access. For these, the bench compares each record with a model that tracks its own reference address.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;
  localparam int TC_W = 6;
  localparam logic [TC_W-1:0] TC_WRITE = 6'd5;
  localparam logic [TC_W-1:0] TC_READ  = 6'd6;
  localparam logic [TC_W-1:0] TC_SYNC  = 6'd13;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_ANY   = 2'd3
  } kind_e;
endpackage

// File: rtl/dtrace_qualify.sv
module dtrace_qualify
  import dtrace_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  output logic          win_ok,
  output logic          kind_ok,
  output logic          hit
);
  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] l,
                                     input logic [AW-1:0] h);
    // empty window when l > h falls out naturally
    return (a >= l) && (a <= h);
  endfunction

  function automatic logic dir_allowed(input kind_e k, input logic wr);
    logic r;
    case (k)
      KIND_READ:  r = !wr;
      KIND_WRITE: r = wr;
      KIND_ANY:   r = 1'b1;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

  always_comb begin
    win_ok  = in_window(acc_addr, lo, hi);
    kind_ok = dir_allowed(kind_e'(kind), acc_write);
    hit     = en && acc_valid && win_ok && kind_ok;
  end
endmodule

// File: rtl/dtrace_xor_trim.sv
module dtrace_xor_trim #(
  parameter int AW = 32,
  parameter int LW = $clog2(AW + 1)
) (
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] diff,
  output logic [LW-1:0] sig_len
);
  function automatic logic [LW-1:0] significant_bits(input logic [AW-1:0] v);
    logic [LW-1:0] n;
    n = '0;
    for (int i = 0; i < AW; i++) begin
      if (v[i]) n = LW'(i + 1);
    end
    return n;
  endfunction

  always_comb begin
    diff    = ref_addr ^ cur_addr;
    sig_len = significant_bits(diff);
  end
endmodule

// File: rtl/dtrace_ref_state.sv
module dtrace_ref_state #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          hit,
  input  logic          full,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] ref_addr,
  output logic          need_sync,
  output logic          emit,
  output logic          drop
);
  assign emit = hit && !full;
  assign drop = hit && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr  <= '0;
      need_sync <= 1'b1;
    end else begin
      if (!en || drop) need_sync <= 1'b1;
      else if (emit)   need_sync <= 1'b0;
      if (emit) ref_addr <= cur_addr;
    end
  end
endmodule

// File: rtl/dtrace_msg_gen.sv
module dtrace_msg_gen
  import dtrace_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic [1:0]      cfg_kind,
  input  logic [AW-1:0]   cfg_lo,
  input  logic [AW-1:0]   cfg_hi,
  input  logic            bus_valid,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_write,
  input  logic [DW-1:0]   bus_data,
  input  logic            oq_full,
  output logic            msg_valid,
  output logic [TC_W-1:0] msg_tcode,
  output logic            msg_write,
  output logic [LW-1:0]   msg_alen,
  output logic [AW-1:0]   msg_addr,
  output logic [DW-1:0]   msg_data
);
  // named internal events, observed by the bound checker
  logic          win_ok, kind_ok, hit_evt;
  logic          emit_evt, drop_evt, need_sync;
  logic [AW-1:0] ref_addr, diff;
  logic [LW-1:0] diff_len;

  dtrace_qualify #(.AW(AW)) u_qual (
    .en(cfg_enable), .kind(cfg_kind), .lo(cfg_lo), .hi(cfg_hi),
    .acc_valid(bus_valid), .acc_addr(bus_addr), .acc_write(bus_write),
    .win_ok(win_ok), .kind_ok(kind_ok), .hit(hit_evt)
  );

  dtrace_ref_state #(.AW(AW)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .hit(hit_evt),
    .full(oq_full), .cur_addr(bus_addr), .ref_addr(ref_addr),
    .need_sync(need_sync), .emit(emit_evt), .drop(drop_evt)
  );

  dtrace_xor_trim #(.AW(AW), .LW(LW)) u_trim (
    .ref_addr(ref_addr), .cur_addr(bus_addr),
    .diff(diff), .sig_len(diff_len)
  );

  function automatic logic [TC_W-1:0] pick_code(input logic sync, input logic wr);
    if (sync) return TC_SYNC;
    return wr ? TC_WRITE : TC_READ;
  endfunction

  logic [TC_W-1:0] nxt_code;
  logic [LW-1:0]   nxt_len;
  logic [AW-1:0]   nxt_addr;

  always_comb begin
    nxt_code = pick_code(need_sync, bus_write);
    nxt_len  = need_sync ? LW'(AW) : diff_len;
    nxt_addr = need_sync ? bus_addr : diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_tcode <= '0;
      msg_write <= 1'b0;
      msg_alen  <= '0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      msg_valid <= emit_evt;
      if (emit_evt) begin
        msg_tcode <= nxt_code;
        msg_write <= bus_write;
        msg_alen  <= nxt_len;
        msg_addr  <= nxt_addr;
        msg_data  <= bus_data;
      end
    end
  end
endmodule

// File: rtl/dtrace_msg_gen_chk.sv
module dtrace_msg_gen_chk
  import dtrace_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = $clog2(AW + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_enable,
  input logic            bus_valid,
  input logic            oq_full,
  input logic            drop_evt,
  input logic            need_sync,
  input logic            msg_valid,
  input logic [TC_W-1:0] msg_tcode,
  input logic            msg_write,
  input logic [LW-1:0]   msg_alen,
  input logic [AW-1:0]   msg_addr
);
  logic [2*AW-1:0] wide_addr;
  assign wide_addr = {{AW{1'b0}}, msg_addr};

  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_tcode == TC_WRITE || msg_tcode == TC_READ || msg_tcode == TC_SYNC));

  assert_code_matches_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_tcode != TC_SYNC |-> (msg_write == (msg_tcode == TC_WRITE)));

  assert_len_bounds_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_tcode != TC_SYNC |-> ((wide_addr >> msg_alen) == '0));

  assert_sync_full_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_tcode == TC_SYNC |-> msg_alen == LW'(AW));

  assert_sync_when_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_tcode == TC_SYNC) == $past(need_sync)));

  assert_no_msg_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !msg_valid);

  assert_no_msg_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oq_full |=> !msg_valid);

  assert_drop_arms_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> need_sync);

  assert_msg_follows_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(bus_valid));
endmodule

bind dtrace_msg_gen dtrace_msg_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .bus_valid(bus_valid),
  .oq_full(oq_full), .drop_evt(drop_evt), .need_sync(need_sync),
  .msg_valid(msg_valid), .msg_tcode(msg_tcode), .msg_write(msg_write),
  .msg_alen(msg_alen), .msg_addr(msg_addr)
);

// File: tb/dtrace_msg_gen_tb.sv
`timescale 1ns/1ps
module dtrace_msg_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_kind = 2'd0;
  logic [31:0] cfg_lo = '0, cfg_hi = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, oq_full = 1'b0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        msg_valid, msg_write;
  logic [5:0]  msg_tcode, msg_alen;
  logic [31:0] msg_addr, msg_data;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_ref = '0;
  bit          m_sync = 1;

  always #4 clk = ~clk;

  dtrace_msg_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_kind(cfg_kind),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_data(bus_data), .oq_full(oq_full),
    .msg_valid(msg_valid), .msg_tcode(msg_tcode), .msg_write(msg_write),
    .msg_alen(msg_alen), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic int count_bits(input logic [31:0] x);
    int n = 0;
    logic [31:0] v = x;
    while (v != 0) begin v = v >> 1; n++; end
    return n;
  endfunction

  function automatic bit qualifies(input bit en, input logic [1:0] k,
                                   input logic [31:0] lo, input logic [31:0] hi,
                                   input bit v, input logic [31:0] a, input bit w);
    bit dir = (k == 2'd3) || (k == 2'd1 && !w) || (k == 2'd2 && w);
    return en && v && dir && !(a < lo) && !(a > hi);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then check the record one clock later
  task automatic step(input string tag, input bit v, input logic [31:0] a,
                      input bit w, input logic [31:0] d, input bit full);
    bit q, e;
    logic [5:0] ecode, elen;
    logic [31:0] eaddr;
    bus_valid = v; bus_addr = a; bus_write = w; bus_data = d; oq_full = full;
    q = qualifies(cfg_enable, cfg_kind, cfg_lo, cfg_hi, v, a, w);
    e = q && !full;
    ecode = m_sync ? 6'd13 : (w ? 6'd5 : 6'd6);
    elen  = m_sync ? 6'd32 : 6'(count_bits(m_ref ^ a));
    eaddr = m_sync ? a : (m_ref ^ a);
    if (!cfg_enable || (q && full)) m_sync = 1;
    else if (e) m_sync = 0;
    if (e) m_ref = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "msg_valid", 32'(msg_valid), 32'(e));
    if (e && msg_valid) begin
      chk("R6", "msg_tcode", 32'(msg_tcode), 32'(ecode));
      chk("R6", "msg_alen", 32'(msg_alen), 32'(elen));
      chk("R6", "msg_addr", msg_addr, eaddr);
      chk("R10", "msg_data", msg_data, d);
      chk("R2", "msg_write", 32'(msg_write), 32'(w));
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 32'h0, 0, 32'h0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1", "msg_valid in reset", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "msg_valid after reset", 32'(msg_valid), 32'd0);

    cfg_lo = 32'h1000_0400; cfg_hi = 32'h1000_2FFF; cfg_kind = 2'd3;
    // R4: disabled, nothing reported
    step("R4", 1, 32'h1000_0800, 1, 32'hAAAA_0001, 0);
    cfg_enable = 1'b1;
    // R5: first record after enable is a full sync
    step("R5", 1, 32'h1000_0800, 1, 32'h1111_2222, 0);
    // R7: same address again gives zero-length difference
    step("R7", 1, 32'h1000_0800, 0, 32'h3333_4444, 0);
    step("R6", 1, 32'h1000_0A10, 1, 32'h5555_6666, 0);
    // R9: idle cycle produces no record
    idle("R9");
    // R3: boundaries included, one below and one above excluded
    step("R3", 1, 32'h1000_0400, 0, 32'h0000_0001, 0);
    step("R3", 1, 32'h1000_2FFF, 1, 32'h0000_0002, 0);
    step("R3", 1, 32'h1000_03FF, 1, 32'h0000_0003, 0);
    step("R3", 1, 32'h1000_3000, 1, 32'h0000_0004, 0);
    // R2: read-only and write-only filters
    cfg_kind = 2'd1;
    step("R2", 1, 32'h1000_0500, 1, 32'h0000_0005, 0);
    step("R2", 1, 32'h1000_0504, 0, 32'h0000_0006, 0);
    cfg_kind = 2'd2;
    step("R2", 1, 32'h1000_0508, 0, 32'h0000_0007, 0);
    step("R2", 1, 32'h1000_050C, 1, 32'h0000_0008, 0);
    cfg_kind = 2'd0;
    step("R2", 1, 32'h1000_0510, 1, 32'h0000_0009, 0);
    cfg_kind = 2'd3;
    // R8: dropped record, then sync
    step("R8", 1, 32'h1000_0600, 1, 32'h0000_000A, 1);
    step("R8", 1, 32'h1000_0604, 0, 32'h0000_000B, 0);
    step("R8", 1, 32'h1000_0608, 0, 32'h0000_000C, 0);
    // R3: empty window when low bound exceeds high bound
    cfg_lo = 32'h2000_0000; cfg_hi = 32'h1FFF_FFFF;
    step("R3", 1, 32'h2000_0000, 1, 32'h0000_000D, 0);
    cfg_lo = 32'h0000_0000; cfg_hi = 32'hFFFF_FFFF;
    step("R6", 1, 32'hFFFF_FFFF, 1, 32'h0000_000E, 0);
    step("R6", 1, 32'h0000_0000, 0, 32'h0000_000F, 0);
    // R5: re-enable forces sync
    cfg_enable = 1'b0;
    step("R4", 1, 32'h0000_0040, 1, 32'h0000_0010, 0);
    cfg_enable = 1'b1;
    step("R5", 1, 32'h0000_0044, 1, 32'h0000_0011, 0);

    // constrained random phase
    cfg_lo = 32'h1000_0400; cfg_hi = 32'h1000_2FFF;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      if (($urandom % 64) == 0) cfg_enable = ~cfg_enable;
      if (($urandom % 100) == 0) cfg_kind = 2'($urandom);
      a = (($urandom % 8) == 0) ? $urandom : (32'h1000_0000 | ($urandom & 32'h0000_3FFF));
      step("R6", ($urandom % 4) != 0, a, 1'($urandom), $urandom, ($urandom % 8) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule